// File: doc/BRIEF.md
# Capture-Compare Timer with Guarded Event Flags

This block is a small timer peripheral. A free-running up-counter advances by one per clock while the run bit is set. A writable match register raises a match flag whenever the counter steps onto its value. A read-only snapshot register loads the count when a chosen edge arrives on an external timer input, and raises a snapshot flag. Software reaches the block through a plain register port with an address, read and write strobes, and a data bus as wide as the counter.

Both flags sit in one status word and drive an interrupt line when the interrupt enable is set. Software clears the flags by writing zero to the status word. That write only removes a flag that an earlier status read saw as set. An event that lands after the read therefore stays pending and cannot be lost.

The register word addresses are: 0 control, 1 match value, 2 snapshot value, 3 current count, 4 status. Any other address reads zero.

Top module: `cct_timer`

## Requirements
- R1: After reset the control word reads 0, the match register reads all ones, the snapshot register reads 0, the count reads 0, the status word reads 0 and `irq` is low.
- R2: The counter rises by one on every clock while control bit 0 (run) is 1, holds while it is 0, and wraps from all ones to zero.
- R3: Status bit 0 (match flag) sets on the clock at which the counter advances to a value equal to the match register. Writing the match register with the count that is currently held sets nothing.
- R4: The timer input passes through two synchronising flops. Control bits 2:1 choose the snapshot edge: 00 none, 01 rising, 10 falling, 11 both. On a chosen edge the snapshot register loads the counter and status bit 1 (snapshot flag) sets. Bus writes to the snapshot register have no effect.
- R5: Read data appears on `bus_rdata` one cycle after the read strobe. In the status word, bit 1 is the snapshot flag, bit 0 is the match flag, and all other bits read 0. Unmapped addresses read 0.
- R6: A write of zero to the status word clears only those flags that a previous status read returned as 1. A nonzero write to the status word has no effect.
- R7: A flag that sets after the last status read survives a clearing write.
- R8: If an event arrives in the same cycle as a clearing write, the flag for that event stays set.
- R9: `irq` is high exactly while control bit 3 (interrupt enable) is 1 and at least one status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| tmr_in | input | 1 | Asynchronous timer input |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit counter and a 3-bit address, so every wrap takes only 256 cycles. With this size the bench can sweep every possible match value and confirm that the flag rises at the exact count, and it can also cross the wrap point many times. The same small counter makes every snapshot edge mode and both edge polarities cheap to repeat at changing counts. It also lets the bench place the clear-versus-event races on exact cycles.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // control word layout: bit3 irq enable, bits2:1 edge select, bit0 run
    typedef struct packed {
        logic      irq_en;
        edge_sel_e edge_sel;
        logic      run;
    } ctrl_t;

    localparam int CTRL_W    = $bits(ctrl_t);
    localparam int FLAG_N    = 2;
    localparam int FLAG_COMP = 0;
    localparam int FLAG_CAPT = 1;

    localparam int ADR_CTRL = 0;
    localparam int ADR_CMP  = 1;
    localparam int ADR_CAP  = 2;
    localparam int ADR_CNT  = 3;
    localparam int ADR_STAT = 4;

endpackage

// File: rtl/cct_sync.sv
module cct_sync
    import cct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      edge_hit
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     synced, rise, fall;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced = st_q.chain[STAGES-1];
    assign rise   = synced & ~st_q.prev;
    assign fall   = ~synced & st_q.prev;

    always_comb begin
        unique case (sel)
            EDGE_NONE: edge_hit = 1'b0;
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = st_q.cnt + 1'b1;

    always_comb begin
        st_d = st_q;
        if (run) st_d.cnt = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign match = run && (cnt_inc == cmp);
endmodule

// File: rtl/cct_flags.sv
module cct_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         rd_stat,
    input  logic         clr,
    output logic [N-1:0] flags,
    output logic [N-1:0] seen
);
    typedef struct packed {
        logic [N-1:0] flag;
        logic [N-1:0] seen;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr && st_q.seen[i]) begin
                st_d.flag[i] = 1'b0;
                st_d.seen[i] = 1'b0;
            end
            if (rd_stat && st_q.flag[i]) st_d.seen[i] = 1'b1;
            if (set[i])                  st_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;
    assign seen  = st_q.seen;
endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              tmr_in,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CMP_RST = '1;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] rdata;
    } regs_t;

    regs_t             r_d, r_q;
    logic [CNT_W-1:0]  cnt;
    logic              comp_hit, capt_hit;
    logic [FLAG_N-1:0] flags, seen;
    logic              sel_ctrl, sel_cmp, sel_cap, sel_cnt, sel_stat;
    logic              rd_stat, clr;
    logic [CNT_W-1:0]  rd_mux;

    assign sel_ctrl = bus_addr == ADDR_W'(ADR_CTRL);
    assign sel_cmp  = bus_addr == ADDR_W'(ADR_CMP);
    assign sel_cap  = bus_addr == ADDR_W'(ADR_CAP);
    assign sel_cnt  = bus_addr == ADDR_W'(ADR_CNT);
    assign sel_stat = bus_addr == ADDR_W'(ADR_STAT);
    assign rd_stat  = bus_rd && sel_stat;
    assign clr      = bus_wr && sel_stat && (bus_wdata == '0);

    cct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.ctrl.run),
        .cmp   (r_q.cmp),
        .cnt   (cnt),
        .match (comp_hit)
    );

    cct_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (tmr_in),
        .sel      (r_q.ctrl.edge_sel),
        .edge_hit (capt_hit)
    );

    cct_flags #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     ({capt_hit, comp_hit}),
        .rd_stat (rd_stat),
        .clr     (clr),
        .flags   (flags),
        .seen    (seen)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) rd_mux = CNT_W'(r_q.ctrl);
        if (sel_cmp)  rd_mux = r_q.cmp;
        if (sel_cap)  rd_mux = r_q.cap;
        if (sel_cnt)  rd_mux = cnt;
        if (sel_stat) rd_mux = CNT_W'(flags);
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr && sel_ctrl) r_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (bus_wr && sel_cmp)  r_d.cmp  = bus_wdata;
        if (capt_hit)           r_d.cap  = cnt;
        if (bus_rd)             r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= '0;
            r_q.cmp   <= CMP_RST;
            r_q.cap   <= '0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign irq       = r_q.ctrl.irq_en && (flags != '0);
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [CNT_W-1:0]  cap,
    input logic [1:0]        flags,
    input logic [1:0]        seen,
    input logic              comp_hit,
    input logic              capt_hit,
    input logic              clr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic              irq
);
    logic [CNT_W-1:0] step;
    assign step = cnt + 1'b1;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == $past(cnt));
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == $past(step));
    assert_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step == cmp) |=> flags[0]);
    assert_capt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capt_hit |=> (cap == $past(cnt)) && flags[1]);
    assert_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(4)) |=> bus_rdata[CNT_W-1:2] == '0);
    assert_guard_comp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !seen[0]) |=> flags[0]);
    assert_guard_capt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !seen[1]) |=> flags[1]);
    assert_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (comp_hit || capt_hit)) |=> (flags[0] || !$past(comp_hit)) && (flags[1] || !$past(capt_hit)));
    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags != 2'b00);
endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (r_q.ctrl.run),
    .cnt       (cnt),
    .cmp       (r_q.cmp),
    .cap       (r_q.cap),
    .flags     (flags),
    .seen      (seen),
    .comp_hit  (comp_hit),
    .capt_hit  (capt_hit),
    .clr       (clr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq)
);

// File: tb/cct_timer_tb.sv
module cct_timer_tb;
    localparam int W = 8;
    localparam int A = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [A-1:0] bus_addr = '0;
    logic         bus_rd = 1'b0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         tmr_in = 1'b0;
    logic         irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [W-1:0] mcnt = '0;
    logic         mrun = 1'b0;

    always #4 clk = ~clk;

    cct_timer #(.CNT_W(W), .ADDR_W(A)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_in(tmr_in), .irq(irq)
    );

    // counter model from R2
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mcnt <= '0;
            mrun <= 1'b0;
        end else begin
            if (mrun) mcnt <= mcnt + 1'b1;
            if (bus_wr && bus_addr == 3'd0) mrun <= bus_wdata[0];
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=%0d exp=<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = A'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = A'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        logic [W-1:0] t;
        rd(4, t);
        wr(4, '0);
    endtask

    // with the counter stopped, produce one match event (R3)
    task automatic fire_comp(input logic [W-1:0] base);
        logic [W-1:0] cur;
        rd(3, cur);
        wr(1, cur + 1'b1);
        wr(0, base | 8'h01);
        wr(0, base);
    endtask

    task automatic toggle_in();
        @(negedge clk);
        tmr_in = ~tmr_in;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] v, exp, prevcap, cur;
        logic hit;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(0, v); chk("R1 ctrl", v, 8'h00);
        rd(1, v); chk("R1 cmp", v, 8'hFF);
        rd(2, v); chk("R1 cap", v, 8'h00);
        rd(3, v); chk("R1 cnt", v, 8'h00);
        rd(4, v); chk("R1 stat", v, 8'h00);

        // R5 unmapped
        for (int a = 5; a < 8; a++) begin
            rd(a, v); chk("R5 unmapped", v, 8'h00);
        end

        // R2 counting and wrap
        wr(0, 8'h01);
        for (int k = 0; k < 6; k++) begin
            repeat (97) @(negedge clk);
            exp = mcnt;
            bus_addr = 3'd3; bus_rd = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0;
            chk("R2 running count", bus_rdata, exp);
        end
        wr(0, 8'h00);
        rd(3, v); chk("R2 held count", v, mcnt);
        repeat (20) @(negedge clk);
        rd(3, v); chk("R2 hold", v, mcnt);

        // R3 sweep of every match value
        for (int c = 0; c < 256; c++) begin
            wr(0, 8'h08);
            wr(1, W'(c));
            clear_all();
            chk("R9 irq low after clear", {7'd0, irq}, 8'h00);
            wr(0, 8'h09);
            hit = 1'b0;
            for (int t = 0; t < 300 && !hit; t++) begin
                @(negedge clk);
                if (irq) begin
                    hit = 1'b1;
                    chk("R3 match at count", mcnt, W'(c));
                end
            end
            if (!hit) chk("R3 match never seen", 8'h00, 8'h01);
        end
        wr(0, 8'h00);

        // R3 write of held count sets nothing
        clear_all();
        rd(3, cur);
        wr(1, cur);
        repeat (5) @(negedge clk);
        rd(4, v); chk("R3 no flag on write", v, 8'h00);

        // R4 edge modes, two rounds at different counts
        rd(2, prevcap);
        for (int round = 0; round < 2; round++) begin
            for (int s = 0; s < 4; s++) begin
                wr(0, W'((s << 1) | 1));
                for (int e = 0; e < 2; e++) begin
                    wr(0, W'((s << 1) | 1));
                    clear_all();
                    @(negedge clk);
                    tmr_in = ~tmr_in;
                    @(posedge clk);
                    @(posedge clk);
                    @(negedge clk);
                    exp = mcnt;
                    hit = (s == 3) || (s == 1 && tmr_in) || (s == 2 && !tmr_in);
                    wr(0, 8'h00);
                    rd(4, v); chk("R4 capt flag", v & 8'h02, hit ? 8'h02 : 8'h00);
                    rd(2, v);
                    if (hit) prevcap = exp;
                    chk("R4 capt value", v, prevcap);
                end
                repeat (13 + 37 * round) @(negedge clk);
            end
        end
        wr(2, 8'h5A);
        rd(2, v); chk("R4 cap write ignored", v, prevcap);

        // R6 guarded clear
        wr(0, 8'h06);
        clear_all(); clear_all();
        fire_comp(8'h06);
        wr(4, 8'h00);
        rd(4, v); chk("R6 unseen survives", v, 8'h01);
        wr(4, 8'h00);
        rd(4, v); chk("R6 seen clears", v, 8'h00);
        fire_comp(8'h06);
        rd(4, v); chk("R6 flag up", v, 8'h01);
        wr(4, 8'h03);
        rd(4, v); chk("R6 nonzero ignored", v, 8'h01);
        wr(4, 8'h00);
        rd(4, v); chk("R6 clear after nonzero", v, 8'h00);

        // R7 late event survives
        toggle_in();
        rd(4, v); chk("R7 capt seen", v, 8'h02);
        fire_comp(8'h06);
        wr(4, 8'h00);
        rd(4, v); chk("R7 late comp survives", v, 8'h01);
        wr(4, 8'h00);
        rd(4, v); chk("R7 final clear", v, 8'h00);

        // R8 event coincides with clear
        toggle_in();
        rd(4, v); chk("R8 capt up", v, 8'h02);
        @(negedge clk);
        tmr_in = ~tmr_in;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = '0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4, v); chk("R8 event wins", v, 8'h02);
        wr(4, 8'h00);
        rd(4, v); chk("R8 later clear", v, 8'h00);

        // R9 irq gating
        toggle_in();
        chk("R9 irq off when disabled", {7'd0, irq}, 8'h00);
        wr(0, 8'h0E);
        chk("R9 irq on", {7'd0, irq}, 8'h01);
        clear_all();
        chk("R9 irq drops", {7'd0, irq}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule